// File: doc/BRIEF.md
# Branch Prediction Table

This block is a direct-mapped table that a fetch stage consults every cycle to guess whether the instruction at the current fetch address is a taken branch and, if it is, where fetch should go next. Each slot holds a valid bit, a tag formed from the upper address bits, the last known destination address and a small direction state. The lookup is purely combinational on the fetch address. When there is no matching slot, the answer is "not taken".

A second port receives resolved branches from later in the pipeline: the branch address, whether it really went, and where it really went. The block reads the matching slot in that same cycle and judges whether the guess it would have given was wrong. It raises a one-cycle mispredict flag on the next cycle, which the pipeline uses to clear the control bits of younger instructions. The slot is updated at the same clock edge. A parameter chooses between a one-bit scheme, where the state copies the last outcome, and a two-bit saturating counter scheme.

Top module: `bpt_table`

## Requirements
- R1: After reset every slot is invalid, so any lookup returns hit 0, taken 0 and target 0.
- R2: The slot index is address bits [OFS_W+IDX_W-1:OFS_W] (bits [5:2] by default), and the tag is every bit above them. Two addresses that share an index but differ in tag never hit each other's slot.
- R3: A lookup without a hit reports taken 0 and target 0. A lookup with a hit reports the stored target, and taken equals bit 1 of the stored 2-bit state.
- R4: A resolved taken branch that misses claims its slot with the new tag and target. In four-state mode the state starts at 2'b10 (weakly taken); in two-state mode it starts at 2'b11 (taken). A following lookup of that address therefore hits and predicts taken.
- R5: A resolved not-taken branch that misses leaves the table unchanged.
- R6: In four-state mode a hit moves the state one step toward the outcome and saturates at 2'b00 and 2'b11. Taken is predicted for states 2'b10 and 2'b11.
- R7: In two-state mode a hit sets the state to 2'b11 on a taken outcome and 2'b00 on a not-taken outcome, so the guess always repeats the last outcome.
- R8: The mispredict flag is high in the cycle after a resolve when the real direction differs from the guess taken from the table at the resolve cycle. A miss counts as a not-taken guess.
- R9: A taken branch that hits and is guessed taken, but whose stored target differs from the real target, is also a mispredict. Every taken hit writes the real target into the slot.
- R10: When a lookup and a resolve hit the same slot in the same cycle, the lookup returns the contents from before the update.
- R11: The mispredict flag is low in any cycle that does not follow a resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_pc_i | input | PC_W | Fetch address to look up |
| lk_hit_o | output | 1 | A valid slot with a matching tag exists |
| lk_taken_o | output | 1 | Predicted taken |
| lk_target_o | output | PC_W | Predicted destination (0 when no hit) |
| rs_valid_i | input | 1 | A resolved branch is presented this cycle |
| rs_pc_i | input | PC_W | Address of the resolved branch |
| rs_taken_i | input | 1 | Real direction of the resolved branch |
| rs_target_i | input | PC_W | Real destination of the resolved branch |
| rs_mispredict_o | output | 1 | The guess for the previous cycle's resolve was wrong |

## Verification
The lookup outputs follow the fetch address within the same cycle, and a resolve becomes visible to lookups only from the cycle after its clock edge. The bench therefore checks the lookup a fraction of a nanosecond after it drives the address at the falling edge, before the rising edge applies any update. The mispredict flag is due one cycle after its resolve. The bench computes its expected value from its own table model before the edge and compares it just after that edge, then updates the model. A four-state and a two-state instance run side by side on the same stimulus.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    typedef logic [1:0] bpt_ctr_t;

    localparam bpt_ctr_t CTR_STRONG_NT = 2'b00;
    localparam bpt_ctr_t CTR_WEAK_NT   = 2'b01;
    localparam bpt_ctr_t CTR_WEAK_T    = 2'b10;
    localparam bpt_ctr_t CTR_STRONG_T  = 2'b11;

endpackage

// File: rtl/bpt_pc_split.sv
module bpt_pc_split #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned OFS_W = 2,
    localparam int unsigned TAG_W = PC_W - IDX_W - OFS_W
) (
    input  logic [PC_W-1:0]  pc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [TAG_W-1:0] tag_o
);

    logic unused_ofs;

    assign idx_o      = pc_i[OFS_W +: IDX_W];
    assign tag_o      = pc_i[PC_W-1 : OFS_W+IDX_W];
    assign unused_ofs = ^pc_i[OFS_W-1:0];

endmodule

// File: rtl/bpt_ctr_next.sv
module bpt_ctr_next
    import bpt_pkg::*;
#(
    parameter bit FOUR_STATE = 1'b1
) (
    input  bpt_ctr_t cur_i,
    input  logic     taken_i,
    output bpt_ctr_t nxt_o
);

    generate
        if (FOUR_STATE) begin : g_four
            always_comb begin
                nxt_o = cur_i;
                if (taken_i && cur_i != CTR_STRONG_T) begin
                    nxt_o = cur_i + 2'd1;
                end else if (!taken_i && cur_i != CTR_STRONG_NT) begin
                    nxt_o = cur_i - 2'd1;
                end
            end

            always_comb begin
                // R6
                ctr_sat_chk: assert (!(taken_i && cur_i == CTR_STRONG_T) || nxt_o == CTR_STRONG_T);
                // R6
                ctr_floor_chk: assert (taken_i || cur_i != CTR_STRONG_NT || nxt_o == CTR_STRONG_NT);
            end
        end else begin : g_two
            logic unused_cur;
            assign unused_cur = ^cur_i;
            assign nxt_o      = taken_i ? CTR_STRONG_T : CTR_STRONG_NT;
        end
    endgenerate

endmodule

// File: rtl/bpt_table.sv
module bpt_table
    import bpt_pkg::*;
#(
    parameter int unsigned PC_W       = 32,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned OFS_W      = 2,
    parameter bit          FOUR_STATE = 1'b1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [PC_W-1:0] lk_pc_i,
    output logic            lk_hit_o,
    output logic            lk_taken_o,
    output logic [PC_W-1:0] lk_target_o,
    input  logic            rs_valid_i,
    input  logic [PC_W-1:0] rs_pc_i,
    input  logic            rs_taken_i,
    input  logic [PC_W-1:0] rs_target_i,
    output logic            rs_mispredict_o
);

    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned TAG_W   = PC_W - IDX_W - OFS_W;
    localparam bpt_ctr_t    CTR_NEW = FOUR_STATE ? CTR_WEAK_T : CTR_STRONG_T;

    typedef struct packed {
        logic [ENTRIES-1:0]                 valid;
        logic [ENTRIES-1:0][TAG_W-1:0]      tag;
        logic [ENTRIES-1:0][PC_W-1:0]       tgt;
        logic [ENTRIES-1:0][1:0]            ctr;
        logic                               mispredict;
    } bpt_state_t;

    bpt_state_t st_d, st_q;

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;
    logic             rs_hit, rs_guess_taken, rs_wrong;
    bpt_ctr_t         rs_ctr_nxt;

    bpt_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_lk_split (
        .pc_i  (lk_pc_i),
        .idx_o (lk_idx),
        .tag_o (lk_tag)
    );

    bpt_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_rs_split (
        .pc_i  (rs_pc_i),
        .idx_o (rs_idx),
        .tag_o (rs_tag)
    );

    bpt_ctr_next #(.FOUR_STATE(FOUR_STATE)) u_ctr_next (
        .cur_i   (st_q.ctr[rs_idx]),
        .taken_i (rs_taken_i),
        .nxt_o   (rs_ctr_nxt)
    );

    // Lookup reads registered contents only, so a same-cycle update is not seen.
    assign lk_hit_o        = st_q.valid[lk_idx] && (st_q.tag[lk_idx] == lk_tag);
    assign lk_taken_o      = lk_hit_o && st_q.ctr[lk_idx][1];
    assign lk_target_o     = lk_hit_o ? st_q.tgt[lk_idx] : '0;
    assign rs_mispredict_o = st_q.mispredict;

    // Guess the table would have given for the resolving branch.
    assign rs_hit         = st_q.valid[rs_idx] && (st_q.tag[rs_idx] == rs_tag);
    assign rs_guess_taken = rs_hit && st_q.ctr[rs_idx][1];
    assign rs_wrong       = (rs_taken_i != rs_guess_taken) ||
                            (rs_taken_i && rs_guess_taken && (st_q.tgt[rs_idx] != rs_target_i));

    always_comb begin
        st_d            = st_q;
        st_d.mispredict = 1'b0;
        if (rs_valid_i) begin
            st_d.mispredict = rs_wrong;
            if (rs_hit) begin
                st_d.ctr[rs_idx] = rs_ctr_nxt;
                if (rs_taken_i) begin
                    st_d.tgt[rs_idx] = rs_target_i;
                end
            end else if (rs_taken_i) begin
                st_d.valid[rs_idx] = 1'b1;
                st_d.tag[rs_idx]   = rs_tag;
                st_d.tgt[rs_idx]   = rs_target_i;
                st_d.ctr[rs_idx]   = CTR_NEW;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    miss_not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_hit_o |-> (!lk_taken_o && lk_target_o == '0));

    // R11
    idle_no_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rs_valid_i |=> !rs_mispredict_o);

    // R4
    taken_installs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rs_valid_i && rs_taken_i) |=>
            (st_q.valid[$past(rs_idx)] && st_q.tag[$past(rs_idx)] == $past(rs_tag) &&
             st_q.tgt[$past(rs_idx)] == $past(rs_target_i)));

    // R5
    nt_miss_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rs_valid_i && !rs_taken_i && !rs_hit) |=>
            (st_q.valid == $past(st_q.valid) && st_q.tag == $past(st_q.tag)));

    // R9
    target_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rs_valid_i && rs_taken_i && lk_hit_o && lk_pc_i == rs_pc_i && lk_taken_o &&
         lk_target_o != rs_target_i) |=> rs_mispredict_o);

endmodule

// File: tb/bpt_table_bench.sv
`timescale 1ns/1ps
module bpt_table_bench;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [PC_W-1:0] lk_pc, rs_pc, rs_tgt;
    logic            rs_v, rs_t;
    logic            hit4, tk4, mp4, hit2, tk2, mp2;
    logic [PC_W-1:0] tg4, tg2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bpt_table #(.FOUR_STATE(1'b1)) u_bpt_table (
        .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc),
        .lk_hit_o(hit4), .lk_taken_o(tk4), .lk_target_o(tg4),
        .rs_valid_i(rs_v), .rs_pc_i(rs_pc), .rs_taken_i(rs_t),
        .rs_target_i(rs_tgt), .rs_mispredict_o(mp4)
    );

    bpt_table #(.FOUR_STATE(1'b0)) u_bpt_table_two (
        .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(lk_pc),
        .lk_hit_o(hit2), .lk_taken_o(tk2), .lk_target_o(tg2),
        .rs_valid_i(rs_v), .rs_pc_i(rs_pc), .rs_taken_i(rs_t),
        .rs_target_i(rs_tgt), .rs_mispredict_o(mp2)
    );

    // model, mode 0 = four-state, mode 1 = two-state
    logic            m_valid [2][16];
    logic [25:0]     m_tag   [2][16];
    logic [PC_W-1:0] m_tgt   [2][16];
    logic [1:0]      m_ctr   [2][16];

    function automatic logic [3:0]  f_idx(input logic [PC_W-1:0] pc); return pc[5:2];  endfunction
    function automatic logic [25:0] f_tag(input logic [PC_W-1:0] pc); return pc[31:6]; endfunction

    function automatic logic f_hit(input int m, input logic [PC_W-1:0] pc);
        return m_valid[m][f_idx(pc)] && m_tag[m][f_idx(pc)] == f_tag(pc);
    endfunction

    function automatic logic [1:0] f_next(input int m, input logic [1:0] c, input logic t);
        if (m == 1) return t ? 2'b11 : 2'b00;
        if (t) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    function automatic logic [PC_W+1:0] f_look(input int m, input logic [PC_W-1:0] pc);
        logic h;
        h = f_hit(m, pc);
        return {h, h && m_ctr[m][f_idx(pc)][1], h ? m_tgt[m][f_idx(pc)] : {PC_W{1'b0}}};
    endfunction

    function automatic logic f_mp(input int m, input logic [PC_W-1:0] pc, input logic t,
                                  input logic [PC_W-1:0] tgt);
        logic g;
        g = f_hit(m, pc) && m_ctr[m][f_idx(pc)][1];
        return (t != g) || (t && g && m_tgt[m][f_idx(pc)] != tgt);
    endfunction

    task automatic model_update(input int m, input logic [PC_W-1:0] pc, input logic t,
                                input logic [PC_W-1:0] tgt);
        logic [3:0] i;
        i = f_idx(pc);
        if (f_hit(m, pc)) begin
            m_ctr[m][i] = f_next(m, m_ctr[m][i], t);
            if (t) m_tgt[m][i] = tgt;
        end else if (t) begin
            m_valid[m][i] = 1'b1;
            m_tag[m][i]   = f_tag(pc);
            m_tgt[m][i]   = tgt;
            m_ctr[m][i]   = (m == 0) ? 2'b10 : 2'b11;
        end
    endtask

    task automatic check(input string req, input string what, input logic [PC_W+1:0] act,
                         input logic [PC_W+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input string req, input logic [PC_W-1:0] lpc, input logic v,
                        input logic [PC_W-1:0] rpc, input logic t, input logic [PC_W-1:0] tgt);
        logic e4, e2;
        lk_pc = lpc; rs_v = v; rs_pc = rpc; rs_t = t; rs_tgt = tgt;
        #0.5;
        check(req, "lookup four", {hit4, tk4, tg4}, f_look(0, lpc));
        check(req, "lookup two",  {hit2, tk2, tg2}, f_look(1, lpc));
        e4 = v && f_mp(0, rpc, t, tgt);
        e2 = v && f_mp(1, rpc, t, tgt);
        @(posedge clk);
        #0.5;
        if (v) begin
            model_update(0, rpc, t, tgt);
            model_update(1, rpc, t, tgt);
        end
        check(v ? req : "R11", "mispredict four", {33'd0, mp4}, {33'd0, e4});
        check(v ? req : "R11", "mispredict two",  {33'd0, mp2}, {33'd0, e2});
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    localparam logic [PC_W-1:0] PA = 32'h0000_1008; // index 2
    localparam logic [PC_W-1:0] PB = 32'h0000_1048; // index 2, other tag
    localparam logic [PC_W-1:0] T1 = 32'h0000_4000;
    localparam logic [PC_W-1:0] T2 = 32'h0000_5000;

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 16; i++) begin
                m_valid[m][i] = 1'b0; m_tag[m][i] = '0; m_tgt[m][i] = '0; m_ctr[m][i] = '0;
            end
        end
        rst_n = 1'b0; lk_pc = '0; rs_v = 1'b0; rs_pc = '0; rs_t = 1'b0; rs_tgt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        step("R1", PA, 1'b0, '0, 1'b0, '0);
        step("R1", 32'hFFFF_FFFC, 1'b0, '0, 1'b0, '0);
        step("R5", PA, 1'b1, PA, 1'b0, T1);       // not-taken miss: no flush, no entry
        step("R5", PA, 1'b0, '0, 1'b0, '0);
        step("R8", PA, 1'b1, PA, 1'b1, T1);       // taken miss: flush, install
        step("R4", PA, 1'b0, '0, 1'b0, '0);
        step("R2", PB, 1'b0, '0, 1'b0, '0);       // alias misses
        step("R6", PA, 1'b1, PA, 1'b0, T1);       // 10->01 / 11->00, flush
        step("R7", PA, 1'b0, '0, 1'b0, '0);
        step("R6", PA, 1'b1, PA, 1'b1, T1);       // guessed not taken: flush
        step("R9", PA, 1'b1, PA, 1'b1, T2);       // target change: flush
        step("R9", PA, 1'b0, '0, 1'b0, '0);
        step("R6", PA, 1'b1, PA, 1'b1, T2);       // four: saturates at 11
        step("R10", PA, 1'b1, PA, 1'b0, T2);      // lookup sees old taken entry
        step("R6", PA, 1'b0, '0, 1'b0, '0);       // four 10 still taken, two now not
        step("R2", PB, 1'b1, PB, 1'b1, T1);       // alias replaces slot
        step("R2", PA, 1'b0, '0, 1'b0, '0);
        step("R11", PB, 1'b0, '0, 1'b0, '0);

        for (int n = 0; n < 600; n++) begin
            logic [PC_W-1:0] lp, rp, tg;
            lp = {24'd0, 2'($urandom_range(0, 2)), 4'($urandom_range(0, 3)), 2'b00};
            rp = ($urandom_range(0, 3) == 0) ? lp :
                 {24'd0, 2'($urandom_range(0, 2)), 4'($urandom_range(0, 3)), 2'b00};
            tg = 32'h100 * $urandom_range(1, 3);
            step("R8", lp, ($urandom_range(0, 9) < 7), rp, 1'($urandom_range(0, 1)), tg);
        end

        done = 1'b1;
        finish_run();
    end

endmodule